// File: doc/BRIEF.md
# Watchdog Register Unlock Sequencer

This block guards the write-once configuration of a watchdog. Software writes a two-word key into a 16-bit unlock register. The first word must be 0xC520 and the second must be 0xD928. The second word must arrive no more than 20 bus cycles after the first. A correct key opens an update window that lasts the programmed number of bus cycles. The configuration registers may be rewritten only while `upd_open_o` is high.

A wrong key word, or a second word that arrives too late, is a violation. A violation either requests a system reset at once, or raises an interrupt and requests the reset a fixed number of cycles later. The whole mechanism works only while the allow-update configuration bit is set.

The block also shows the 32-bit watchdog counter as two 16-bit readout halves. The readout freezes in stop mode. It resumes tracking the counter after a short, modelled resume latency.

Top module: `wdog_unlock_seq`

## Requirements
- R1: After reset, `upd_open_o`, `viol_irq_o` and `rst_req_o` are 0 and both readout halves are 0.
- R2: An unlock write of 0xC520 followed by an unlock write of 0xD928 opens the window, provided the second write comes 1 to 20 cycles after the first and `allow_upd_i` is 1 for both. `upd_open_o` goes high in the cycle after the second write. It stays high for exactly `wct_i` cycles and then goes low.
- R3: After a 0xC520 write, a second write 20 cycles later is still accepted. If no write has arrived by that cycle, a violation is signalled in that cycle.
- R4: These unlock writes are violations: a first write of any value other than 0xC520, and a second write of any value other than 0xD928 (0xC520 included).
- R5: When `irq_rst_en_i` is 0, a violation sets `rst_req_o` in the next cycle and `viol_irq_o` stays 0. Both outputs stay set until reset.
- R6: When `irq_rst_en_i` is 1, a violation sets `viol_irq_o` in the next cycle. `rst_req_o` rises exactly IRQ_DLY (default 128) cycles after `viol_irq_o`.
- R7: While `allow_upd_i` is 0, unlock writes of any value are ignored. They open no window and cause no violation.
- R8: After a window opens, the sequencer is idle again. A lone 0xD928 write, with no 0xC520 before it, is a violation.
- R9: Outside stop mode, `tmr_hi_o` and `tmr_lo_o` show the upper and lower halves of the `cnt_i` value sampled at the previous clock edge.
- R10: While `stop_i` is 1, the readout holds its value from before stop. After `stop_i` falls, the readout starts tracking `cnt_i` again after RESUME_DLY (default 4) cycles. It then shows the counter value sampled at the edge RESUME_DLY cycles after the first edge with `stop_i` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unlock_wr_i | input | 1 | Write strobe for the unlock register |
| unlock_data_i | input | 16 | Data written to the unlock register |
| allow_upd_i | input | 1 | Allow-update configuration bit |
| irq_rst_en_i | input | 1 | Interrupt-before-reset enable |
| wct_i | input | 16 | Update window length in bus cycles |
| cnt_i | input | 32 | Live watchdog counter value |
| stop_i | input | 1 | Stop mode indication |
| upd_open_o | output | 1 | Update window is open |
| viol_irq_o | output | 1 | Violation interrupt, held until reset |
| rst_req_o | output | 1 | System reset request, held until reset |
| tmr_hi_o | output | 16 | Upper half of the counter readout |
| tmr_lo_o | output | 16 | Lower half of the counter readout |

## Verification
A wrong sequencer state shows at the ports one cycle after the deciding write. Either `upd_open_o` rises where a violation was due, or `rst_req_o`/`viol_irq_o` rises where a window was due. An error in the key-timeout count shows as a violation one cycle too early or too late, relative to a write placed exactly at the 20-cycle boundary. A wrong delay or window counter shows as the reset request or the window's falling edge moving off its exact cycle. Readout faults show as a stale or premature value in the cycles around the exit from stop.

// File: rtl/wdog_unlock_pkg.sv
package wdog_unlock_pkg;
  localparam logic [15:0] KEY_FIRST  = 16'hC520;
  localparam logic [15:0] KEY_SECOND = 16'hD928;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
endpackage

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_unlock_pkg::*;
#(
  parameter int LIMIT = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] data_i,
  input  logic        allow_i,
  output logic        ok_o,
  output logic        bad_o
);
  localparam int CW = $clog2(LIMIT + 1);

  key_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    ok_o  = 1'b0;
    bad_o = 1'b0;
    st_d  = st_q;
    if (!allow_i) begin
      st_d = KS_IDLE;
    end else begin
      unique case (st_q)
        KS_IDLE: if (wr_i) begin
          if (data_i == KEY_FIRST) st_d = KS_ARMED;
          else                     bad_o = 1'b1;
        end
        KS_ARMED: begin
          if (wr_i) begin
            if (data_i == KEY_SECOND) ok_o = 1'b1;
            else                      bad_o = 1'b1;
            st_d = KS_IDLE;
          end else if (cnt_q == CW'(LIMIT - 1)) begin
            bad_o = 1'b1;
            st_d  = KS_IDLE;
          end
        end
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= KS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == KS_ARMED && st_d == KS_ARMED) ? cnt_q + 1'b1 : '0;
    end
  end

  assert_key_window_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == KS_ARMED |-> cnt_q < CW'(LIMIT));
endmodule

// File: rtl/wdog_upd_window.sv
module wdog_upd_window #(
  parameter int WCT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WCT_W-1:0] len_i,
  output logic             open_o
);
  logic [WCT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);

  assert_window_shrinks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && open_o |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/wdog_viol_ctrl.sv
module wdog_viol_ctrl #(
  parameter int IRQ_DLY = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bad_i,
  input  logic irq_en_i,
  output logic irq_o,
  output logic rst_o
);
  localparam int DW = $clog2(IRQ_DLY + 1);

  logic          pend_q;
  logic [DW-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
      rst_o  <= 1'b0;
      dly_q  <= '0;
    end else if (!pend_q) begin
      if (bad_i) begin
        pend_q <= 1'b1;
        dly_q  <= '0;
        if (irq_en_i) irq_o <= 1'b1;
        else          rst_o <= 1'b1;
      end
    end else if (!rst_o) begin
      dly_q <= dly_q + 1'b1;
      if (dly_q == DW'(IRQ_DLY - 1)) rst_o <= 1'b1;
    end
  end

  assert_rst_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |=> rst_o);
  assert_irq_before_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !rst_o);
endmodule

// File: rtl/wdog_cnt_view.sv
module wdog_cnt_view #(
  parameter int CNT_W      = 32,
  parameter int RESUME_DLY = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               stop_i,
  output logic [CNT_W/2-1:0] hi_o,
  output logic [CNT_W/2-1:0] lo_o
);
  localparam int HW = CNT_W / 2;
  localparam int RW = $clog2(RESUME_DLY + 1);

  logic [CNT_W-1:0] snap_q;
  logic [RW-1:0]    rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      rs_q   <= '0;
    end else begin
      if (stop_i)            rs_q <= RW'(RESUME_DLY);
      else if (rs_q != '0)   rs_q <= rs_q - 1'b1;
      if (!stop_i && rs_q == '0) snap_q <= cnt_i;
    end
  end

  assign hi_o = snap_q[CNT_W-1:HW];
  assign lo_o = snap_q[HW-1:0];

  assert_hold_in_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> $stable({hi_o, lo_o}));
endmodule

// File: rtl/wdog_unlock_seq.sv
module wdog_unlock_seq
  import wdog_unlock_pkg::*;
#(
  parameter int LIMIT      = 20,
  parameter int IRQ_DLY    = 128,
  parameter int WCT_W      = 16,
  parameter int CNT_W      = 32,
  parameter int RESUME_DLY = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               unlock_wr_i,
  input  logic [15:0]        unlock_data_i,
  input  logic               allow_upd_i,
  input  logic               irq_rst_en_i,
  input  logic [WCT_W-1:0]   wct_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               stop_i,
  output logic               upd_open_o,
  output logic               viol_irq_o,
  output logic               rst_req_o,
  output logic [CNT_W/2-1:0] tmr_hi_o,
  output logic [CNT_W/2-1:0] tmr_lo_o
);
  logic key_ok, key_bad;

  wdog_key_fsm #(.LIMIT(LIMIT)) i_key (
    .clk_i, .rst_ni,
    .wr_i   (unlock_wr_i),
    .data_i (unlock_data_i),
    .allow_i(allow_upd_i),
    .ok_o   (key_ok),
    .bad_o  (key_bad)
  );

  wdog_upd_window #(.WCT_W(WCT_W)) i_win (
    .clk_i, .rst_ni,
    .load_i(key_ok),
    .len_i (wct_i),
    .open_o(upd_open_o)
  );

  wdog_viol_ctrl #(.IRQ_DLY(IRQ_DLY)) i_viol (
    .clk_i, .rst_ni,
    .bad_i   (key_bad),
    .irq_en_i(irq_rst_en_i),
    .irq_o   (viol_irq_o),
    .rst_o   (rst_req_o)
  );

  wdog_cnt_view #(.CNT_W(CNT_W), .RESUME_DLY(RESUME_DLY)) i_view (
    .clk_i, .rst_ni,
    .cnt_i, .stop_i,
    .hi_o(tmr_hi_o),
    .lo_o(tmr_lo_o)
  );

  assert_open_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_open_o) |-> $past(unlock_wr_i && allow_upd_i && unlock_data_i == KEY_SECOND));
  assert_ignored_when_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_upd_i && !viol_irq_o && !rst_req_o |=> !$rose(viol_irq_o) && !$rose(rst_req_o));
endmodule

// File: tb/test_wdog_unlock_seq.sv
module test_wdog_unlock_seq;
  localparam logic [15:0] K1 = 16'hC520;
  localparam logic [15:0] K2 = 16'hD928;
  localparam int LIM = 20;
  localparam int DLY = 128;
  localparam int RES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] data = '0;
  logic        allow = 1'b1;
  logic        irq_en = 1'b0;
  logic [15:0] wct = 16'd200;
  logic [31:0] cnt = '0;
  logic        stop = 1'b0;
  logic        open_o, irq_o, rst_o;
  logic [15:0] hi_o, lo_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wdog_unlock_seq i_wdog_unlock_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .unlock_wr_i(wr), .unlock_data_i(data),
    .allow_upd_i(allow), .irq_rst_en_i(irq_en),
    .wct_i(wct), .cnt_i(cnt), .stop_i(stop),
    .upd_open_o(open_o), .viol_irq_o(irq_o), .rst_req_o(rst_o),
    .tmr_hi_o(hi_o), .tmr_lo_o(lo_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_unlock(logic [15:0] v);
    wr = 1'b1;
    data = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr = 1'b0;
    stop = 1'b0;
    allow = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // 0 = window opens, 1 = violation
  function automatic int expect_viol(logic [15:0] a, int gap, logic [15:0] b);
    if (a != K1) return 1;
    if (gap > LIM) return 1;
    return (b == K2) ? 0 : 1;
  endfunction

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    logic [31:0] va, vb;
    int gap, ev;
    void'($urandom(32'd20240607));
    idle(2);
    check("R1 open", {31'd0, open_o}, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 rst", {31'd0, rst_o}, 0);
    check("R1 tmr", {hi_o, lo_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: exact window length
    wct = 16'd5;
    wr_unlock(K1);
    wr_unlock(K2);
    for (int i = 0; i < 6; i++) begin
      check("R2 window", {31'd0, open_o}, (i < 5) ? 1 : 0);
      @(negedge clk);
    end
    check("R2 no viol", {30'd0, irq_o, rst_o}, 0);

    // R8: lone second key after window is a violation
    irq_en = 1'b0;
    wr_unlock(K2);
    check("R8 lone key2 rst", {31'd0, rst_o}, 1);
    check("R8 no open", {31'd0, open_o}, 0);

    // R3: boundary gap 20 accepted
    do_reset();
    wct = 16'd50;
    wr_unlock(K1);
    idle(LIM - 1);
    wr_unlock(K2);
    check("R3 gap20 open", {31'd0, open_o}, 1);
    check("R3 gap20 no viol", {31'd0, rst_o}, 0);

    // R3: timeout fires at cycle 20
    do_reset();
    wr_unlock(K1);
    idle(LIM - 1);
    check("R3 before timeout", {31'd0, rst_o}, 0);
    idle(1);
    check("R3 timeout", {31'd0, rst_o}, 1);

    // R4: key1 repeated as second word
    do_reset();
    wr_unlock(K1);
    wr_unlock(K1);
    check("R4 key1 twice", {31'd0, rst_o}, 1);
    check("R5 irq low", {31'd0, irq_o}, 0);
    idle(5);
    check("R5 sticky", {31'd0, rst_o}, 1);

    // R6: interrupt then delayed reset
    do_reset();
    irq_en = 1'b1;
    wr_unlock(16'h1234);
    check("R6 irq", {31'd0, irq_o}, 1);
    check("R6 rst pending", {31'd0, rst_o}, 0);
    idle(DLY - 1);
    check("R6 rst not yet", {31'd0, rst_o}, 0);
    idle(1);
    check("R6 rst at delay", {31'd0, rst_o}, 1);

    // R7: locked writes ignored
    do_reset();
    irq_en = 1'b0;
    allow = 1'b0;
    wr_unlock(16'h0BAD);
    wr_unlock(K1);
    wr_unlock(K2);
    check("R7 no viol", {30'd0, irq_o, rst_o}, 0);
    check("R7 no open", {31'd0, open_o}, 0);
    allow = 1'b1;

    // R2-R6 random sequences
    for (int t = 0; t < 30; t++) begin
      do_reset();
      wct = 16'd200;
      irq_en = $urandom_range(0, 1);
      a = ($urandom_range(0, 7) == 0) ? 16'($urandom) : K1;
      b = ($urandom_range(0, 3) == 0) ? 16'($urandom) : K2;
      gap = $urandom_range(1, 24);
      ev = expect_viol(a, gap, b);
      wr_unlock(a);
      if (a == K1) begin
        if (gap > LIM) idle(LIM);
        else begin
          idle(gap - 1);
          wr_unlock(b);
        end
      end
      check("R4 rand open", {31'd0, open_o}, (ev == 0) ? 1 : 0);
      check("R5 rand rst", {31'd0, rst_o}, (ev == 1 && !irq_en) ? 1 : 0);
      check("R6 rand irq", {31'd0, irq_o}, (ev == 1 && irq_en) ? 1 : 0);
    end

    // R9: readout tracks counter
    do_reset();
    for (int t = 0; t < 8; t++) begin
      va = $urandom;
      cnt = va;
      @(negedge clk);
      check("R9 readout", {hi_o, lo_o}, va);
    end

    // R10: hold in stop, resume after RES cycles
    va = 32'hA5A5_0101;
    vb = 32'h5A5A_F0F0;
    cnt = va;
    @(negedge clk);
    stop = 1'b1;
    cnt = vb;
    idle(3);
    check("R10 hold", {hi_o, lo_o}, va);
    stop = 1'b0;
    idle(RES);
    check("R10 still held", {hi_o, lo_o}, va);
    idle(1);
    check("R10 resumed", {hi_o, lo_o}, vb);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule